// File: doc/BRIEF.md
# Serial ADC Frame Master Controller

This block is the host side of a 16-clock serial link to a four-channel successive-approximation converter. A one-cycle start request opens a frame: chip-select goes low, and the block then produces exactly sixteen serial clock pulses, derived from the system clock by an even divide ratio. While those clocks run, it shifts out a 12-bit control word, MSB first, followed by four zero bits. On every falling serial clock edge it samples the converter's reply.

At the end of the frame the reply is decoded. Two bits name the converter channel the sample came from, and the result field is taken at the configured resolution (12, 10 or 8 bits) with the padding removed. A framing flag marks a reply whose two leading bits are not zero, or whose trailing padding is not zero. A one-cycle done pulse marks the cycle in which the result registers take new values. Between frames, chip-select stays high for at least one full serial clock period, so the converter always sees a quiet interval.

Top module: `adc_frame_master`

## Requirements
- R1: After reset, chip-select and the serial clock are both high, and busy and done are low.
- R2: Each frame has exactly 16 falling serial clock edges while chip-select is low. The serial clock is high again before chip-select rises.
- R3: The serial clock period is CLK_DIV system clock cycles, and its low and high phases are equal.
- R4: The data output sends bit 11 of the control word first, down to bit 0, on the first 12 falling edges. It sends zero on falling edges 13 to 16.
- R5: The reply bit sampled on falling edge k is reply bit 16-k, so the first bit sampled is bit 15. The channel output is reply bits [13:12], with bit 13 as the high bit.
- R6: The result is reply bits [11:0] for RES_BITS=12, [11:2] for RES_BITS=10 and [11:4] for RES_BITS=8.
- R7: The framing-error flag is high when reply bit 15 or bit 14 is 1, or when any reply bit below the result field is 1. Otherwise it is low.
- R8: Done is high for exactly one system cycle, in the first cycle in which the channel, result and error outputs show the new frame, and only while chip-select is high.
- R9: A start request that arrives while busy is high is ignored. It does not start a further frame and does not change the control word being sent.
- R10: Between the end of one frame and the start of the next, chip-select stays high for at least CLK_DIV system cycles, even when start is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Request one frame; taken only while idle |
| ctrl_word_i | input | 12 | Control word to send, write-enable flag in bit 11 |
| miso_i | input | 1 | Serial reply from the converter |
| csn_o | output | 1 | Active-low chip-select |
| sclk_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial control data to the converter |
| busy_o | output | 1 | High from frame start through the quiet interval |
| done_o | output | 1 | One-cycle pulse when the results update |
| chan_o | output | 2 | Channel tag of the last reply |
| result_o | output | RES_BITS | Conversion result of the last reply |
| frame_err_o | output | 1 | Framing error of the last reply |

## Verification
A fault in the half-period step counter appears at the ports within one frame. The bench would see the wrong number of falling edges before chip-select rises, chip-select rising while the clock is low, or a changed clock period on the second falling edge. A fault in the shift registers or the decode logic appears in the outputs latched at the next done pulse, where channel, result and error are compared with the reply the bench's converter model sent. A fault in the quiet-interval or start-gating logic appears as a chip-select gap that is too short, or as an extra frame after a start request made during a busy frame. Both are measured within the frame that follows.

// File: rtl/adc_fm_pkg.sv
package adc_fm_pkg;
  localparam int FRAME_LEN = 16;
  localparam int CTRL_LEN  = 12;
  localparam int PAD_LEN   = FRAME_LEN - CTRL_LEN;
  // Half-period steps in a frame: lead-in, 32 clock halves, hold-off
  localparam int LAST_STEP = 2 * FRAME_LEN;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_QUIET = 2'd2
  } fm_state_e;
endpackage

// File: rtl/adc_fm_timer.sv
module adc_fm_timer #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == CW'(HALF - 1));

  always_comb begin
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_fm_seq.sv
module adc_fm_seq
  import adc_fm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tick_i,
  output logic run_o,
  output logic busy_o,
  output logic csn_o,
  output logic sclk_o,
  output logic load_o,
  output logic fall_o,
  output logic rise_o,
  output logic finish_o
);
  fm_state_e   state_q, state_d;
  logic [5:0]  step_q, step_d;
  logic        csn_q, csn_d, sclk_q, sclk_d;

  assign run_o    = (state_q != ST_IDLE);
  assign busy_o   = run_o;
  assign csn_o    = csn_q;
  assign sclk_o   = sclk_q;
  assign load_o   = (state_q == ST_IDLE) && start_i;
  assign fall_o   = tick_i && (state_q == ST_FRAME) && !step_q[0] && (step_q != 6'(LAST_STEP));
  assign rise_o   = tick_i && (state_q == ST_FRAME) && step_q[0];
  assign finish_o = tick_i && (state_q == ST_FRAME) && (step_q == 6'(LAST_STEP));

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_FRAME;
          step_d  = '0;
        end
      end
      ST_FRAME: begin
        if (tick_i) begin
          if (step_q == 6'(LAST_STEP)) begin
            state_d = ST_QUIET;
            step_d  = '0;
          end else begin
            step_d  = step_q + 1'b1;
          end
        end
      end
      ST_QUIET: begin
        if (tick_i) begin
          if (step_q[0]) begin
            state_d = ST_IDLE;
            step_d  = '0;
          end else begin
            step_d  = step_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        step_d  = '0;
      end
    endcase
    csn_d  = (state_d != ST_FRAME);
    sclk_d = !((state_d == ST_FRAME) && step_d[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      csn_q   <= 1'b1;
      sclk_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      csn_q   <= csn_d;
      sclk_q  <= sclk_d;
    end
  end
endmodule

// File: rtl/adc_fm_shift.sv
module adc_fm_shift
  import adc_fm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic                 fall_i,
  input  logic                 rise_i,
  input  logic [CTRL_LEN-1:0]  ctrl_i,
  input  logic                 miso_i,
  output logic                 mosi_o,
  output logic [FRAME_LEN-1:0] rx_o
);
  logic [FRAME_LEN-1:0] tx_q, tx_d, rx_q, rx_d;

  assign mosi_o = tx_q[FRAME_LEN-1];
  assign rx_o   = rx_q;

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    if (load_i)      tx_d = {ctrl_i, {PAD_LEN{1'b0}}};
    else if (rise_i) tx_d = {tx_q[FRAME_LEN-2:0], 1'b0};
    if (fall_i)      rx_d = {rx_q[FRAME_LEN-2:0], miso_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end
endmodule

// File: rtl/adc_fm_decode.sv
module adc_fm_decode
  import adc_fm_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 finish_i,
  input  logic [FRAME_LEN-1:0] rx_i,
  output logic                 done_o,
  output logic [1:0]           chan_o,
  output logic [RES_BITS-1:0]  result_o,
  output logic                 err_o
);
  localparam int TRAIL = CTRL_LEN - RES_BITS;

  logic pad_nz;
  logic lead_nz;

  generate
    if (TRAIL > 0) begin : g_pad
      assign pad_nz = |rx_i[TRAIL-1:0];
    end else begin : g_nopad
      assign pad_nz = 1'b0;
    end
  endgenerate

  assign lead_nz = rx_i[FRAME_LEN-1] | rx_i[FRAME_LEN-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o   <= 1'b0;
      chan_o   <= '0;
      result_o <= '0;
      err_o    <= 1'b0;
    end else begin
      done_o <= finish_i;
      if (finish_i) begin
        chan_o   <= rx_i[FRAME_LEN-3:FRAME_LEN-4];
        result_o <= rx_i[CTRL_LEN-1 -: RES_BITS];
        err_o    <= lead_nz | pad_nz;
      end
    end
  end
endmodule

// File: rtl/adc_frame_master.sv
module adc_frame_master
  import adc_fm_pkg::*;
#(
  parameter int CLK_DIV  = 4,
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [11:0]         ctrl_word_i,
  input  logic                miso_i,
  output logic                csn_o,
  output logic                sclk_o,
  output logic                mosi_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [1:0]          chan_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                frame_err_o
);
  logic [1:0] rst_sync_q;
  logic       srst_n;
  logic       run, tick, load, fall, rise, finish;
  logic [FRAME_LEN-1:0] rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  adc_fm_timer #(.CLK_DIV(CLK_DIV)) u_timer (
    .clk(clk), .rst_n(srst_n), .run_i(run), .tick_o(tick)
  );

  adc_fm_seq u_seq (
    .clk(clk), .rst_n(srst_n), .start_i(start_i), .tick_i(tick),
    .run_o(run), .busy_o(busy_o), .csn_o(csn_o), .sclk_o(sclk_o),
    .load_o(load), .fall_o(fall), .rise_o(rise), .finish_o(finish)
  );

  adc_fm_shift u_shift (
    .clk(clk), .rst_n(srst_n), .load_i(load), .fall_i(fall), .rise_i(rise),
    .ctrl_i(ctrl_word_i), .miso_i(miso_i), .mosi_o(mosi_o), .rx_o(rx)
  );

  adc_fm_decode #(.RES_BITS(RES_BITS)) u_dec (
    .clk(clk), .rst_n(srst_n), .finish_i(finish), .rx_i(rx),
    .done_o(done_o), .chan_o(chan_o), .result_o(result_o), .err_o(frame_err_o)
  );
endmodule

// File: rtl/adc_frame_master_chk.sv
module adc_frame_master_chk #(
  parameter int CLK_DIV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic csn_o,
  input logic sclk_o,
  input logic busy_o,
  input logic done_o
);
  localparam int GW = $clog2(CLK_DIV + 1) + 1;

  logic [GW-1:0] gap_q;
  logic [4:0]    falls_q;
  logic          sclk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q       <= GW'(CLK_DIV);
      falls_q     <= '0;
      sclk_prev_q <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_o;
      if (!csn_o)                      gap_q <= '0;
      else if (gap_q < GW'(CLK_DIV))   gap_q <= gap_q + 1'b1;
      if (csn_o)                       falls_q <= '0;
      else if (sclk_prev_q && !sclk_o) falls_q <= falls_q + 1'b1;
    end
  end

  // R2
  idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_o |-> sclk_o);

  // R2
  sixteen_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csn_o) |-> (falls_q == 5'd16));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> csn_o);

  // R9
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csn_o) |-> !$past(busy_o));

  // R10
  quiet_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csn_o) |-> (gap_q >= GW'(CLK_DIV)));
endmodule

bind adc_frame_master adc_frame_master_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .csn_o(csn_o),
  .sclk_o(sclk_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/sim_adc_frame_master.sv
module sim_adc_frame_master;
  localparam int CLK_DIV = 4;
  localparam int TCLK    = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [11:0] ctrl;
  logic        miso;
  logic        csn0, sclk0, mosi0, busy0, done0, err0;
  logic [1:0]  chan0;
  logic [11:0] res0;
  logic        csn1, sclk1, mosi1, busy1, done1, err1;
  logic [1:0]  chan1;
  logic [7:0]  res1;

  int checks = 0;
  int failures = 0;
  int frames = 0;
  int nfall = 0;
  logic [15:0] cap;
  logic [15:0] sw_q = 16'h0;
  longint tprev, per, t_rise, gap;
  logic sclk_at_rise;

  always #2 clk = ~clk;

  adc_frame_master #(.CLK_DIV(CLK_DIV), .RES_BITS(12)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ctrl_word_i(ctrl), .miso_i(miso),
    .csn_o(csn0), .sclk_o(sclk0), .mosi_o(mosi0), .busy_o(busy0), .done_o(done0),
    .chan_o(chan0), .result_o(res0), .frame_err_o(err0)
  );

  adc_frame_master #(.CLK_DIV(CLK_DIV), .RES_BITS(8)) u1 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ctrl_word_i(ctrl), .miso_i(miso),
    .csn_o(csn1), .sclk_o(sclk1), .mosi_o(mosi1), .busy_o(busy1), .done_o(done1),
    .chan_o(chan1), .result_o(res1), .frame_err_o(err1)
  );

  // Converter model: bit 15 valid at chip-select fall, next bit after each falling edge
  initial begin
    miso = 1'b0;
    forever begin
      @(negedge csn0);
      #1 miso = sw_q[15];
      for (int b = 14; b >= 0; b--) begin
        @(negedge sclk0);
        #1 miso = sw_q[b];
      end
    end
  end

  initial t_rise = 0;
  always @(negedge csn0) begin
    gap = $time - t_rise;
    cap = '0;
    nfall = 0;
    frames++;
  end
  always @(negedge sclk0) begin
    if (!csn0) begin
      cap = {cap[14:0], mosi0};
      nfall++;
      if (nfall == 2) per = $time - tprev;
      tprev = $time;
    end
  end
  always @(posedge csn0) begin
    sclk_at_rise = sclk0;
    t_rise = $time;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic exp_err(input logic [15:0] w, input int rb);
    logic e;
    e = w[15] | w[14];
    if (rb == 8)  e = e | (|w[3:0]);
    if (rb == 10) e = e | (|w[1:0]);
    return e;
  endfunction

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy0; i++) @(negedge clk);
  endtask

  task automatic run_frame(input logic [11:0] c, input logic [15:0] w);
    wait_idle();
    sw_q = w;
    ctrl = c;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 2000 && !done0; i++) @(negedge clk);
    chk(done0 && done1, "R8 done pulse", {done0, done1}, 2'b11);
    chk(csn0, "R8 done with chip-select high", csn0, 1);
    chk(chan0 == w[13:12], "R5 channel 12b", chan0, w[13:12]);
    chk(chan1 == w[13:12], "R5 channel 8b", chan1, w[13:12]);
    chk(res0 == w[11:0], "R6 result 12b", res0, w[11:0]);
    chk(res1 == w[11:4], "R6 result 8b", res1, w[11:4]);
    chk(err0 == exp_err(w, 12), "R7 error 12b", err0, exp_err(w, 12));
    chk(err1 == exp_err(w, 8), "R7 error 8b", err1, exp_err(w, 8));
    chk(cap == {c, 4'h0}, "R4 sent word", cap, {c, 4'h0});
    chk(nfall == 16, "R2 falling edges", nfall, 16);
    chk(sclk_at_rise == 1'b1, "R2 clock high at deselect", sclk_at_rise, 1);
    chk(per == CLK_DIV * TCLK, "R3 serial clock period", per, CLK_DIV * TCLK);
    @(negedge clk);
    chk(!done0 && !done1, "R8 done one cycle", {done0, done1}, 0);
  endtask

  initial begin
    #(200000 * TCLK);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int f0;
    logic [15:0] w;
    logic [11:0] c;
    start = 1'b0;
    ctrl  = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(csn0 && sclk0 && csn1 && sclk1, "R1 idle lines", {csn0, sclk0}, 2'b11);
    chk(!busy0 && !done0, "R1 busy and done low", {busy0, done0}, 0);

    // Directed corner cases
    run_frame(12'h800, 16'h0000);
    run_frame(12'hFFF, 16'h3FF0);
    run_frame(12'hA5C, 16'h1ABC);
    run_frame(12'h123, 16'h8123);
    run_frame(12'h000, 16'h4000);
    run_frame(12'h7E1, 16'h2FFF);
    run_frame(12'h555, 16'h3000);

    // R9: start during a frame is ignored
    wait_idle();
    f0 = frames;
    sw_q = 16'h1234;
    ctrl = 12'h9C3;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (20) @(negedge clk);
    ctrl = 12'h0F0;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 2000 && !done0; i++) @(negedge clk);
    chk(cap == {12'h9C3, 4'h0}, "R9 word unchanged by busy start", cap, {12'h9C3, 4'h0});
    wait_idle();
    repeat (3 * CLK_DIV) @(negedge clk);
    chk(frames == f0 + 1, "R9 no extra frame", frames - f0, 1);
    chk(csn0 && !busy0, "R9 stays idle", {csn0, busy0}, 2'b10);

    // R10: start held high, measure the chip-select gap
    f0 = frames;
    ctrl = 12'h3C3;
    @(negedge clk) start = 1'b1;
    for (int i = 0; i < 4000 && frames < f0 + 2; i++) @(negedge clk);
    start = 1'b0;
    chk(frames == f0 + 2, "R10 back-to-back frames ran", frames - f0, 2);
    chk(gap >= CLK_DIV * TCLK, "R10 quiet gap", gap, CLK_DIV * TCLK);
    for (int i = 0; i < 2000 && !done0; i++) @(negedge clk);
    wait_idle();

    // Constrained random frames
    void'($urandom(32'h5EED));
    for (int n = 0; n < 24; n++) begin
      c = 12'($urandom);
      w = 16'($urandom);
      if ($urandom % 4 != 0) w[15:14] = 2'b00;
      if ($urandom % 2 == 0) w[3:0] = 4'h0;
      run_frame(c, w);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule